// File: doc/BRIEF.md
# Interrupt line and DMA channel selector

This block holds two 8-bit control registers that choose which interrupt line and which DMA request channel an audio function uses. Software writes them through a simple register port; a separate legacy configuration port can also change either choice directly. Each register keeps a software-owned upper nibble. Its lower nibble cannot be written: on every read it shows a code generated from the current selection.

The decoded interrupt number and DMA channel are driven out continuously for the logic that does the real signalling. Bit 6 of the DMA register is brought out as a DMA enable. When a register write flips that bit, a one-cycle pulse asks the DMA engine to refresh its status. A change through the legacy port forces bit 7 of both registers high, so software can see that the setup came from the legacy path.

Top module: `irq_dma_select`

## Requirements
- R1: After reset the interrupt register reads 0x05 and the DMA register reads 0x0A. irq_num is 5, dma_chan is 1, dma_valid is 1 and dma_toggle is 0.
- R2: A register write to either register stores only wr_data[7:4] as that register's upper nibble. The readback bits 3:0 never take the written low bits.
- R3: A write to the interrupt register (address IRQ_ADDR, default 0xB1) selects the interrupt line from wr_data[3:2]: 00 gives irq_num 2, 01 gives 5, 10 gives 7 and 11 gives 10. irq_num changes in the cycle after the write.
- R4: A write to the DMA register (address DMA_ADDR, default 0xB2) selects the channel from wr_data[3:2]. 00 gives no channel (dma_valid 0). 01 gives channel 0, 10 gives channel 1 and 11 gives channel 3, each with dma_valid 1.
- R5: Readback bits 3:0 of the interrupt register are 0x0 for IRQ 2, 0x5 for IRQ 5, 0xA for IRQ 7 and 0xF for IRQ 10. Those of the DMA register are 0x0 for no channel, 0x5 for channel 0, 0xA for channel 1 and 0xF for channel 3.
- R6: A register write to one register leaves the other register's upper nibble and selection unchanged.
- R7: A legacy-port update sets the selection it carries. It sets bit 7 of both registers and keeps their bits 6:4. A register write writes bit 7 from wr_data[7] like the other upper bits.
- R8: dma_enable equals readback bit 6 of the DMA register. A DMA-register write whose wr_data[6] differs from the stored bit 6 makes dma_toggle high for exactly the cycle after the write. No other write pulses it.
- R9: When a register write and a legacy update hit the same selection in one cycle, the legacy selection wins. The upper nibble still comes from the write, with bit 7 forced to 1.
- R10: Reads of any other address return 0x00. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Combinational read data |
| leg_irq_we | input | 1 | Legacy port: load interrupt selection |
| leg_irq_sel | input | 2 | Legacy interrupt selection code (same coding as R3) |
| leg_dma_we | input | 1 | Legacy port: load DMA selection |
| leg_dma_sel | input | 2 | Legacy DMA selection code (same coding as R4) |
| irq_num | output | 4 | Selected interrupt number |
| dma_chan | output | 2 | Selected DMA channel |
| dma_valid | output | 1 | A DMA channel is selected |
| dma_enable | output | 1 | DMA register bit 6 |
| dma_toggle | output | 1 | One-cycle DMA status-update pulse |

## Verification
The hardest state to reach is a register write that lands in the same cycle as a legacy update. The write's upper nibble, the forced bit 7 and the winning legacy selection must then merge correctly. Random stimulus enables each path on its own, so both often fire together. Directed steps also force this overlap, and force back-to-back writes that flip bit 6. The bench model tracks both upper nibbles, so it also catches a bit-6 pulse computed from stale stored data.

// File: rtl/irq_dma_select.sv
module irq_dma_select #(
  parameter int AW = 8,
  parameter logic [AW-1:0] IRQ_ADDR = 8'hB1,
  parameter logic [AW-1:0] DMA_ADDR = 8'hB2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          leg_irq_we,
  input  logic [1:0]    leg_irq_sel,
  input  logic          leg_dma_we,
  input  logic [1:0]    leg_dma_sel,
  output logic [3:0]    irq_num,
  output logic [1:0]    dma_chan,
  output logic          dma_valid,
  output logic          dma_enable,
  output logic          dma_toggle
);
  logic [3:0] irq_hi, dma_hi;
  logic [1:0] irq_sel, dma_sel;

  wire wr_irq = wr_en && (wr_addr == IRQ_ADDR);
  wire wr_dma = wr_en && (wr_addr == DMA_ADDR);
  wire leg_any = leg_irq_we || leg_dma_we;
  wire unused_low = ^wr_data[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_hi     <= 4'h0;
      dma_hi     <= 4'h0;
      irq_sel    <= 2'b01;
      dma_sel    <= 2'b10;
      dma_toggle <= 1'b0;
    end else begin
      dma_toggle <= wr_dma && (wr_data[6] != dma_hi[2]);
      if (wr_irq) begin
        irq_hi  <= {wr_data[7] | leg_any, wr_data[6:4]};
        irq_sel <= leg_irq_we ? leg_irq_sel : wr_data[3:2];
      end else begin
        if (leg_any)    irq_hi[3] <= 1'b1;
        if (leg_irq_we) irq_sel   <= leg_irq_sel;
      end
      if (wr_dma) begin
        dma_hi  <= {wr_data[7] | leg_any, wr_data[6:4]};
        dma_sel <= leg_dma_we ? leg_dma_sel : wr_data[3:2];
      end else begin
        if (leg_any)    dma_hi[3] <= 1'b1;
        if (leg_dma_we) dma_sel   <= leg_dma_sel;
      end
    end
  end

  always_comb begin
    case (irq_sel)
      2'b00:   irq_num = 4'd2;
      2'b01:   irq_num = 4'd5;
      2'b10:   irq_num = 4'd7;
      default: irq_num = 4'd10;
    endcase
  end

  assign dma_valid  = (dma_sel != 2'b00);
  assign dma_chan   = (dma_sel == 2'b11) ? 2'd3 : (dma_sel == 2'b10) ? 2'd1 : 2'd0;
  assign dma_enable = dma_hi[2];

  always_comb begin
    if (rd_addr == IRQ_ADDR)      rd_data = {irq_hi, irq_sel, irq_sel};
    else if (rd_addr == DMA_ADDR) rd_data = {dma_hi, dma_sel, dma_sel};
    else                          rd_data = 8'h00;
  end
endmodule

// File: rtl/irq_dma_select_chk.sv
module irq_dma_select_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] IRQ_ADDR = 8'hB1,
  parameter logic [AW-1:0] DMA_ADDR = 8'hB2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          leg_irq_we,
  input logic          leg_dma_we,
  input logic [3:0]    irq_num,
  input logic [1:0]    dma_chan,
  input logic          dma_valid,
  input logic          dma_enable,
  input logic          dma_toggle,
  input logic [3:0]    irq_hi,
  input logic [3:0]    dma_hi
);
  logic [3:0] irq_code;
  always_comb begin
    case (irq_num)
      4'd5:    irq_code = 4'h5;
      4'd7:    irq_code = 4'hA;
      4'd10:   irq_code = 4'hF;
      default: irq_code = 4'h0;
    endcase
  end

  assert_irq_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_num == 4'd2 || irq_num == 4'd5 || irq_num == 4'd7 || irq_num == 4'd10);

  assert_dma_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> dma_chan != 2'd2);

  assert_irq_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == IRQ_ADDR |-> rd_data[3:0] == irq_code);

  assert_keep_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == IRQ_ADDR && !leg_irq_we && !leg_dma_we) |=> $stable(dma_hi));

  assert_legacy_bit7_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_irq_we || leg_dma_we) |=> (irq_hi[3] && dma_hi[3]));

  assert_toggle_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_toggle |-> ($past(wr_en) && $past(wr_addr) == DMA_ADDR && $past(wr_data[6]) != $past(dma_enable)));

  assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != IRQ_ADDR && wr_addr != DMA_ADDR && !leg_irq_we && !leg_dma_we)
      |=> ($stable(irq_hi) && $stable(dma_hi) && $stable(irq_num) && $stable(dma_chan) && $stable(dma_valid)));
endmodule

bind irq_dma_select irq_dma_select_chk #(.AW(AW), .IRQ_ADDR(IRQ_ADDR), .DMA_ADDR(DMA_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .leg_irq_we(leg_irq_we), .leg_dma_we(leg_dma_we),
  .irq_num(irq_num), .dma_chan(dma_chan), .dma_valid(dma_valid), .dma_enable(dma_enable),
  .dma_toggle(dma_toggle), .irq_hi(irq_hi), .dma_hi(dma_hi)
);

// File: tb/irq_dma_select_tb.sv
module irq_dma_select_tb_top;
  localparam logic [7:0] A_IRQ = 8'hB1;
  localparam logic [7:0] A_DMA = 8'hB2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, leg_irq_we = 1'b0, leg_dma_we = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00, rd_data;
  logic [1:0] leg_irq_sel = 2'b00, leg_dma_sel = 2'b00, dma_chan;
  logic [3:0] irq_num;
  logic dma_valid, dma_enable, dma_toggle;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_ihi = 4'h0, m_dhi = 4'h0;
  logic [1:0] m_isel = 2'b01, m_dsel = 2'b10;
  logic m_pulse = 1'b0;

  always #5 clk = ~clk;

  irq_dma_select dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .leg_irq_we(leg_irq_we), .leg_irq_sel(leg_irq_sel),
    .leg_dma_we(leg_dma_we), .leg_dma_sel(leg_dma_sel), .irq_num(irq_num),
    .dma_chan(dma_chan), .dma_valid(dma_valid), .dma_enable(dma_enable), .dma_toggle(dma_toggle)
  );

  function automatic logic [3:0] f_irq(input logic [1:0] s);
    case (s)
      2'b00: return 4'd2;
      2'b01: return 4'd5;
      2'b10: return 4'd7;
      default: return 4'd10;
    endcase
  endfunction

  function automatic logic [1:0] f_chan(input logic [1:0] s);
    case (s)
      2'b01: return 2'd0;
      2'b10: return 2'd1;
      2'b11: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] f_code(input logic [1:0] s);
    case (s)
      2'b01: return 4'h5;
      2'b10: return 4'hA;
      2'b11: return 4'hF;
      default: return 4'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 irq_num"}, irq_num, f_irq(m_isel));
    chk({tag, " R4 dma_valid"}, dma_valid, m_dsel != 2'b00);
    if (m_dsel != 2'b00) chk({tag, " R4 dma_chan"}, dma_chan, f_chan(m_dsel));
    chk({tag, " R8 dma_enable"}, dma_enable, m_dhi[2]);
    chk({tag, " R8 dma_toggle"}, dma_toggle, m_pulse);
    rd_addr = A_IRQ; #1;
    chk({tag, " R2/R5/R7 irq reg"}, rd_data, {m_ihi, f_code(m_isel)});
    rd_addr = A_DMA; #1;
    chk({tag, " R2/R5/R6 dma reg"}, rd_data, {m_dhi, f_code(m_dsel)});
    rd_addr = 8'h40; #1;
    chk({tag, " R10 other read"}, rd_data, 8'h00);
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic li, input logic [1:0] lis,
                      input logic ld, input logic [1:0] lds, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    leg_irq_we = li; leg_irq_sel = lis; leg_dma_we = ld; leg_dma_sel = lds;
    @(posedge clk); #1;
    wr_en = 1'b0; leg_irq_we = 1'b0; leg_dma_we = 1'b0;
    m_pulse = we && a == A_DMA && d[6] != m_dhi[2];
    if (we && a == A_IRQ) begin m_ihi = d[7:4]; m_isel = d[3:2]; end
    if (we && a == A_DMA) begin m_dhi = d[7:4]; m_dsel = d[3:2]; end
    if (li) m_isel = lis;
    if (ld) m_dsel = lds;
    if (li || ld) begin m_ihi[3] = 1'b1; m_dhi[3] = 1'b1; end
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    #1; check_all("R1 reset");
    chk("R1 irq_num", irq_num, 4'd5);
    chk("R1 dma_chan", dma_chan, 2'd1);
    @(negedge clk); rst_n = 1'b1;
    step(1, A_IRQ, 8'h33, 0, 0, 0, 0, "R2 low bits ignored");
    step(1, A_IRQ, 8'h7C, 0, 0, 0, 0, "R3 irq10");
    step(1, A_IRQ, 8'h08, 0, 0, 0, 0, "R3 irq7");
    step(1, A_DMA, 8'h40, 0, 0, 0, 0, "R4 none R8 set");
    step(0, 8'h00, 8'h00, 0, 0, 0, 0, "R8 pulse ends");
    step(1, A_DMA, 8'h44, 0, 0, 0, 0, "R8 no change");
    step(1, A_DMA, 8'h0C, 0, 0, 0, 0, "R4 ch3 R8 clear");
    step(1, A_DMA, 8'h48, 0, 0, 0, 0, "R8 back-to-back");
    step(1, A_IRQ, 8'h50, 0, 0, 0, 0, "R6 other kept");
    step(1, 8'h40, 8'hFF, 0, 0, 0, 0, "R10 other write");
    step(0, 8'h00, 8'h00, 1, 2'b11, 0, 0, "R7 legacy irq");
    step(1, A_IRQ, 8'h24, 0, 0, 0, 0, "R7 write clears bit7");
    step(0, 8'h00, 8'h00, 0, 0, 1, 2'b01, "R7 legacy dma");
    step(1, A_DMA, 8'h30, 1, 2'b00, 1, 2'b11, "R9 overlap");
    step(1, A_IRQ, 8'h6C, 1, 2'b01, 0, 0, "R9 overlap irq");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0: a = A_IRQ;
        1: a = A_DMA;
        2: a = 8'($urandom);
        default: a = A_DMA;
      endcase
      step(($urandom % 3) != 0, a, 8'($urandom), ($urandom % 5) == 0, 2'($urandom),
           ($urandom % 5) == 0, 2'($urandom), "random R2 R3 R4 R5 R7 R8 R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule